// File: doc/BRIEF.md
# Timer and Event Counter with Interrupt Arbitration

This block holds an 8-bit up-counter that a processor core can run in one of two ways. In timer mode the counter advances once every 32 machine cycles, paced by an internal prescaler. In event mode it advances on each falling edge of an external event pin. The pin is first passed through a synchronizer. The core controls the block with single-cycle command strobes: start timer, start event counting, stop, timer-interrupt enable and disable, overflow-flag clear, and a direct counter write. The counter value can be read on a plain output at all times.

When the counter wraps from its maximum value to zero, a sticky overflow flag is raised. A timer interrupt request is also latched if the timer interrupt is enabled. The block also decides which interrupt the core takes at an instruction boundary. A pending, enabled external request wins over the timer request, and both need the master interrupt enable. All pins are plain control and status levels or strobes. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_evt_unit`

## Requirements
- R1: After an active-low reset the counter reads 0, the overflow flag and the pending timer request are 0, both count modes are off, and the timer interrupt is disabled.
- R2: In timer mode the counter advances by one every 32 cycles. A start-timer strobe clears the prescaler, so the first advance after a start lands on the 32nd rising edge after the edge that accepted the strobe.
- R3: In event mode a falling edge on `ev_in` advances the counter by one. The pin passes through two synchronizer flops, so a level sampled low at edge n after a high at edge n-1 advances the counter at edge n+2. Timer and event advances that fall in the same cycle add a single step.
- R4: A stop strobe turns off both modes. It also suppresses any advance in its own cycle, and the counter then holds its value. Stop wins over a start in the same cycle.
- R5: A wrap from 255 to 0 sets `ovf_flag`. The flag stays set until a clear strobe. If a wrap and a clear land in the same cycle, the flag stays set.
- R6: A wrap sets `tmr_pend` only while the timer interrupt is enabled. With the interrupt disabled, a wrap leaves `tmr_pend` low.
- R7: A disable strobe clears the timer-interrupt enable and any pending timer request on the next edge. Disable wins over enable in the same cycle.
- R8: A counter write loads `cnt_wdata` on the next edge and overrides an advance or wrap in that cycle.
- R9: With `boundary` and `master_en` high, `take_ext` is asserted when `ext_pend` and `ext_en` are high. Otherwise `take_tmr` is asserted when `tmr_pend` and the timer enable are high. At most one of the two is ever high.
- R10: Taking the timer request (`take_tmr` high at an edge) clears `tmr_pend` at that edge, unless a new wrap in the same cycle sets it again.
- R11: Neither take output is asserted while `boundary` or `master_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start_tmr | input | 1 | Start timer mode, clear prescaler |
| cmd_start_evt | input | 1 | Start event-count mode |
| cmd_stop | input | 1 | Stop both modes |
| cmd_tint_en | input | 1 | Enable timer interrupt |
| cmd_tint_dis | input | 1 | Disable timer interrupt, drop pending request |
| cmd_flag_clr | input | 1 | Clear overflow flag |
| cnt_wr | input | 1 | Load counter from `cnt_wdata` |
| cnt_wdata | input | 8 | Counter load value |
| cnt_rdata | output | 8 | Current counter value |
| ev_in | input | 1 | Asynchronous event pin, falling edges counted |
| ext_pend | input | 1 | External interrupt request pending |
| ext_en | input | 1 | External interrupt enable |
| master_en | input | 1 | Master interrupt enable |
| boundary | input | 1 | Instruction boundary, arbitration point |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| tmr_pend | output | 1 | Pending timer interrupt request |
| take_ext | output | 1 | External request taken this cycle |
| take_tmr | output | 1 | Timer request taken this cycle |

## Verification
A wrong prescaler value shows on `cnt_rdata` within one 32-cycle period, as an advance that comes early or late. A synchronizer that is off by a stage shows the edge after a falling event. A stale enable or pending bit shows on `take_tmr` at the next boundary. It also shows on `tmr_pend` on the edge after a wrap. A reference model in the bench tracks every output on every cycle, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // run state of the counter: both modes may be active together
  typedef struct packed {
    logic tmr_run;
    logic evt_run;
  } run_mode_t;

  localparam run_mode_t RUN_IDLE = '{tmr_run: 1'b0, evt_run: 1'b0};
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic hold,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == LAST) && !restart && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
    end else if (run) begin
      if (pcnt == LAST) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
    end
  end

  // R2: after a tick the prescaler starts a new period from zero
  a_r2_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));

  // R2: a restart always empties the prescaler
  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shr;

  always_ff @(posedge clk) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[STAGES-1:0], din};
  end

  assign fall = shr[STAGES] & ~shr[STAGES-1];

  // R3: an edge pulse is never two cycles long
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_arb.sv
module tmr_arb (
  input  logic boundary,
  input  logic master_en,
  input  logic ext_pend,
  input  logic ext_en,
  input  logic tmr_pend,
  input  logic tmr_en,
  output logic take_ext,
  output logic take_tmr
);
  logic gate;
  logic ext_ready;
  logic tmr_ready;

  assign gate      = boundary & master_en;
  assign ext_ready = ext_pend & ext_en;
  assign tmr_ready = tmr_pend & tmr_en;

  // external request has priority at the boundary
  assign take_ext = gate & ext_ready;
  assign take_tmr = gate & tmr_ready & ~ext_ready;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit #(
  parameter int CNT_W       = 8,
  parameter int PRESC_DIV   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start_tmr,
  input  logic             cmd_start_evt,
  input  logic             cmd_stop,
  input  logic             cmd_tint_en,
  input  logic             cmd_tint_dis,
  input  logic             cmd_flag_clr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             ev_in,
  input  logic             ext_pend,
  input  logic             ext_en,
  input  logic             master_en,
  input  logic             boundary,
  output logic             ovf_flag,
  output logic             tmr_pend,
  output logic             take_ext,
  output logic             take_tmr
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  run_mode_t        mode;
  logic             tint_en;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             pend_q;
  logic             tmr_tick;
  logic             ev_fall;
  logic             evt_step;
  logic             cnt_inc;
  logic             wrap;

  // timer path prescaler
  tmr_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode.tmr_run),
    .restart (cmd_start_tmr),
    .hold    (cmd_stop),
    .tick    (tmr_tick)
  );

  // event path synchronizer and falling-edge detector
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ev_in),
    .fall  (ev_fall)
  );

  assign evt_step = mode.evt_run & ev_fall & ~cmd_stop;
  assign cnt_inc  = tmr_tick | evt_step;
  assign wrap     = cnt_inc & ~cnt_wr & (cnt_q == CNT_MAX);

  // run mode: stop dominates both starts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= RUN_IDLE;
    end else if (cmd_stop) begin
      mode <= RUN_IDLE;
    end else begin
      if (cmd_start_tmr) mode.tmr_run <= 1'b1;
      if (cmd_start_evt) mode.evt_run <= 1'b1;
    end
  end

  // counter: a write overrides any advance
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= cnt_wdata;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  // sticky overflow flag: a wrap beats a clear
  always_ff @(posedge clk) begin
    if (!rst_n)            ovf_q <= 1'b0;
    else if (wrap)         ovf_q <= 1'b1;
    else if (cmd_flag_clr) ovf_q <= 1'b0;
  end

  // timer interrupt enable: disable beats enable
  always_ff @(posedge clk) begin
    if (!rst_n)            tint_en <= 1'b0;
    else if (cmd_tint_dis) tint_en <= 1'b0;
    else if (cmd_tint_en)  tint_en <= 1'b1;
  end

  // pending timer request
  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (cmd_tint_dis)     pend_q <= 1'b0;
    else if (wrap && tint_en)  pend_q <= 1'b1;
    else if (take_tmr)         pend_q <= 1'b0;
  end

  tmr_arb u_arb (
    .boundary  (boundary),
    .master_en (master_en),
    .ext_pend  (ext_pend),
    .ext_en    (ext_en),
    .tmr_pend  (pend_q),
    .tmr_en    (tint_en),
    .take_ext  (take_ext),
    .take_tmr  (take_tmr)
  );

  assign cnt_rdata = cnt_q;
  assign ovf_flag  = ovf_q;
  assign tmr_pend  = pend_q;

  // R9: never both grants
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_ext, take_tmr}));

  // R11: no grant outside a boundary or with the master enable low
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary || !master_en) |-> !(take_ext || take_tmr));

  // R8: written value appears on the next edge
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_rdata == $past(cnt_wdata)));

  // R4: stop freezes the counter in its own cycle
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cnt_wr) |=> $stable(cnt_rdata));

  // R4: stop leaves both modes off
  a_r4_modes_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (mode == RUN_IDLE));

  // R5: flag stays up until a clear
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !cmd_flag_clr) |=> ovf_flag);

  // R6: with the interrupt disabled no request appears
  a_r6_no_pend_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tint_en && !tmr_pend) |=> !tmr_pend);

  // R7: disable drops enable and pending request
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tint_dis |=> (!tmr_pend && !tint_en));

  // R10: a taken timer request is gone unless a fresh wrap arrives
  a_r10_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_tmr && !cnt_inc) |=> !tmr_pend);
endmodule

// File: tb/test_tmr_evt_unit.sv
module test_tmr_evt_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start_tmr = 0, cmd_start_evt = 0, cmd_stop = 0;
  logic       cmd_tint_en = 0, cmd_tint_dis = 0, cmd_flag_clr = 0;
  logic       cnt_wr = 0;
  logic [7:0] cnt_wdata = 0;
  logic [7:0] cnt_rdata;
  logic       ev_in = 0, ext_pend = 0, ext_en = 0, master_en = 0, boundary = 0;
  logic       ovf_flag, tmr_pend, take_ext, take_tmr;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tmr_evt_unit i_tmr_evt_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_start_tmr(cmd_start_tmr), .cmd_start_evt(cmd_start_evt),
    .cmd_stop(cmd_stop), .cmd_tint_en(cmd_tint_en), .cmd_tint_dis(cmd_tint_dis),
    .cmd_flag_clr(cmd_flag_clr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .ev_in(ev_in), .ext_pend(ext_pend), .ext_en(ext_en),
    .master_en(master_en), .boundary(boundary), .ovf_flag(ovf_flag),
    .tmr_pend(tmr_pend), .take_ext(take_ext), .take_tmr(take_tmr)
  );

  // ---------------- reference model ----------------
  int m_cnt, m_pc;
  bit m_ton, m_eon, m_ten, m_ovf, m_pend;
  bit ev_hist[$];

  function automatic bit exp_take_ext();
    return boundary && master_en && ext_pend && ext_en;
  endfunction

  function automatic bit exp_take_tmr();
    return boundary && master_en && m_ten && m_pend && !(ext_pend && ext_en);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_ton = 0; m_eon = 0; m_ten = 0; m_ovf = 0; m_pend = 0;
      ev_hist = '{0, 0, 0};
    end else begin
      bit fall, tick, evinc, inc, tt, wrap;
      fall  = ev_hist[0] && !ev_hist[1];
      ev_hist.push_back(ev_in);
      void'(ev_hist.pop_front());
      tick  = m_ton && (m_pc == 31) && !cmd_start_tmr && !cmd_stop;
      evinc = m_eon && fall && !cmd_stop;
      inc   = tick || evinc;
      tt    = exp_take_tmr();
      wrap  = inc && !cnt_wr && (m_cnt == 255);
      if (cmd_start_tmr) m_pc = 0;
      else if (m_ton)    m_pc = (m_pc + 1) % 32;
      if (cmd_stop) begin m_ton = 0; m_eon = 0; end
      else begin
        if (cmd_start_tmr) m_ton = 1;
        if (cmd_start_evt) m_eon = 1;
      end
      if (cnt_wr)   m_cnt = cnt_wdata;
      else if (inc) m_cnt = (m_cnt + 1) % 256;
      if (wrap) m_ovf = 1; else if (cmd_flag_clr) m_ovf = 0;
      if (cmd_tint_dis)         m_pend = 0;
      else if (wrap && m_ten)   m_pend = 1;
      else if (tt)              m_pend = 0;
      if (cmd_tint_dis) m_ten = 0; else if (cmd_tint_en) m_ten = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(cnt_rdata == m_cnt[7:0], "R2 R3 R4 R8 count", cnt_rdata, m_cnt);
    chk(ovf_flag == m_ovf, "R5 flag", ovf_flag, m_ovf);
    chk(tmr_pend == m_pend, "R6 R7 R10 pending", tmr_pend, m_pend);
    chk(take_ext == exp_take_ext(), "R9 R11 take_ext", take_ext, exp_take_ext());
    chk(take_tmr == exp_take_tmr(), "R9 R10 R11 take_tmr", take_tmr, exp_take_tmr());
  endtask

  // inputs set at a negedge; compared before the next posedge; strobes cleared after it
  task automatic cyc();
    #3;
    compare();
    @(negedge clk);
    cmd_start_tmr = 0; cmd_start_evt = 0; cmd_stop = 0;
    cmd_tint_en = 0; cmd_tint_dis = 0; cmd_flag_clr = 0; cnt_wr = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    run(3);
    // R1 reset state
    chk(cnt_rdata == 0, "R1 count", cnt_rdata, 0);
    chk(ovf_flag == 0 && tmr_pend == 0, "R1 flags", {ovf_flag, tmr_pend}, 0);
    rst_n = 1;
    run(2);

    // R2 first advance exactly 32 edges after start
    cmd_start_tmr = 1; cyc();
    run(31); chk(cnt_rdata == 0, "R2 early", cnt_rdata, 0);
    cyc();   chk(cnt_rdata == 1, "R2 first step", cnt_rdata, 1);
    // R2 restart mid-period clears prescaler
    run(20);
    cmd_start_tmr = 1; cyc();
    run(31); chk(cnt_rdata == 1, "R2 restart", cnt_rdata, 1);
    cyc();   chk(cnt_rdata == 2, "R2 restart step", cnt_rdata, 2);

    // R4 stop holds
    cmd_stop = 1; cyc();
    run(40); chk(cnt_rdata == 2, "R4 stopped", cnt_rdata, 2);

    // R5 R6 wrap with interrupt disabled
    cnt_wr = 1; cnt_wdata = 8'hFE; cyc();
    chk(cnt_rdata == 8'hFE, "R8 load", cnt_rdata, 8'hFE);
    cmd_start_tmr = 1; cyc();
    run(64);
    chk(ovf_flag == 1, "R5 set on wrap", ovf_flag, 1);
    chk(tmr_pend == 0, "R6 no request while disabled", tmr_pend, 0);
    run(10);
    cmd_flag_clr = 1; cyc();
    chk(ovf_flag == 0, "R5 cleared", ovf_flag, 0);

    // R6 wrap with interrupt enabled
    cmd_tint_en = 1; cyc();
    cnt_wr = 1; cnt_wdata = 8'hFF; cyc();
    run(40);
    chk(tmr_pend == 1, "R6 request set", tmr_pend, 1);

    // R9 external wins, then timer taken, R10 clears
    ext_pend = 1; ext_en = 1; master_en = 1; boundary = 1;
    #2; chk(take_ext == 1 && take_tmr == 0, "R9 ext first", {take_ext, take_tmr}, 2'b10);
    cyc();
    ext_pend = 0;
    #2; chk(take_tmr == 1 && take_ext == 0, "R9 timer next", {take_ext, take_tmr}, 2'b01);
    cyc();
    chk(tmr_pend == 0, "R10 taken clears", tmr_pend, 0);
    boundary = 0; cyc();

    // R11 gating, then R7 disable
    cnt_wr = 1; cnt_wdata = 8'hFF; cyc();
    run(40);
    chk(tmr_pend == 1, "R6 second request", tmr_pend, 1);
    master_en = 0; boundary = 1;
    #2; chk(take_tmr == 0, "R11 master low", take_tmr, 0);
    cyc();
    master_en = 1; boundary = 0;
    #2; chk(take_tmr == 0, "R11 no boundary", take_tmr, 0);
    cyc();
    cmd_tint_dis = 1; cyc();
    chk(tmr_pend == 0, "R7 dropped", tmr_pend, 0);
    cnt_wr = 1; cnt_wdata = 8'hFF; cyc();
    run(40);
    chk(tmr_pend == 0, "R7 stays low after wrap", tmr_pend, 0);

    // R8 write on the advance edge
    cmd_stop = 1; cyc();
    cmd_start_tmr = 1; cyc();
    run(31);
    cnt_wr = 1; cnt_wdata = 8'h40; cyc();
    chk(cnt_rdata == 8'h40, "R8 write beats advance", cnt_rdata, 8'h40);
    run(32);
    chk(cnt_rdata == 8'h41, "R2 after write", cnt_rdata, 8'h41);

    // R5 clear coincident with wrap
    cmd_stop = 1; cyc();
    cnt_wr = 1; cnt_wdata = 8'hFF; cmd_start_tmr = 1; cyc();
    run(31);
    cmd_flag_clr = 1; cyc();
    chk(ovf_flag == 1 && cnt_rdata == 0, "R5 wrap beats clear", ovf_flag, 1);

    // R3 event counting with varied widths
    cmd_stop = 1; cyc();
    cnt_wr = 1; cnt_wdata = 0; cmd_start_evt = 1; cyc();
    for (int k = 0; k < 6; k++) begin
      ev_in = 1; run(1 + (k % 4));
      ev_in = 0; run(1 + ((k * 3) % 5));
    end
    ev_in = 1; run(4);
    chk(cnt_rdata == 6, "R3 six falls", cnt_rdata, 6);
    // R3 latency: low sampled at edge n counts at edge n+2
    ev_in = 0; cyc();
    cyc(); chk(cnt_rdata == 6, "R3 sync delay", cnt_rdata, 6);
    cyc(); chk(cnt_rdata == 7, "R3 counted", cnt_rdata, 7);

    // R4 stop in event mode
    cmd_stop = 1; cyc();
    for (int k = 0; k < 4; k++) begin
      ev_in = 1; run(2);
      ev_in = 0; run(2);
    end
    chk(cnt_rdata == 7, "R4 events ignored", cnt_rdata, 7);

    // both modes together
    cmd_start_evt = 1; cmd_start_tmr = 1; cyc();
    for (int k = 0; k < 20; k++) begin
      ev_in = ~ev_in; run(3 + (k % 7));
    end
    run(8);
    finish_run();
  end
endmodule